// File: doc/BRIEF.md
# Multi-Mode Programmable Delay Timer

This block measures out a programmable delay that is launched by a transition on a trigger input. It shapes one output level according to one of four behaviours, chosen by a 2-bit mode input: one-shot, delayed operate, delayed release and dual delay. A single countdown engine serves all four modes. The modes differ in which trigger edge launches the countdown, which edge forces the output at once, and what level the output takes when the countdown runs out.

The delay length is an 8-bit binary-weighted word, counted in time-base ticks. A tick is either every clock cycle or one pulse out of a parameterised division of the clock. Two division factors are available, with defaults of 3000 and 3600, so that delays can be built from a mains-derived or crystal-derived clock. The trigger is sampled on the falling clock edge. Its transitions are recognised at the following rising edge. A synchronous reset aborts any running delay and returns the output to its idle level. The block has no streaming data path, so every pin is a plain control or status signal.

Top module: `prog_delay_timer`

## Requirements
- R1: The mode input selects the behaviour as follows: 2'b00 one-shot, 2'b01 delayed operate, 2'b10 delayed release, 2'b11 dual delay.
- R2: One-shot: a rising trigger edge drives `dout` low after that clock edge and launches the delay. When the delay expires, `dout` returns high.
- R3: One-shot: a rising edge during a running delay restarts the countdown from its full length, including when it lands on the expiry cycle. A falling edge leaves both `dout` and the countdown untouched.
- R4: Delayed operate: a rising edge launches the delay and `dout` goes low at expiry. A falling edge drives `dout` high at once and cancels any running delay.
- R5: Delayed release: a falling edge launches the delay and `dout` goes high at expiry. A rising edge drives `dout` low at once and cancels any running delay.
- R6: Dual delay: either edge launches or restarts the delay. At expiry, `dout` takes the inverse of the sampled trigger level.
- R7: With a delay word N and a tick period of D clocks, expiry happens (N+1)*D rising edges after the edge that launched the delay. N=0 expires on the first tick.
- R8: With `pre_en`=0 the tick period is 1 clock. With `pre_en`=1 it is DIV_A clocks when `pre_alt`=0 and DIV_B clocks when `pre_alt`=1. The tick phase restarts at each launch.
- R9: `trig` is sampled on the falling clock edge, and a change is acted on at the next rising edge. A pulse that does not span a falling edge is ignored.
- R10: While `rst` is high at a rising edge, any running delay is aborted. The output is then set to high in modes 00 and 01, and to the inverse of the sampled trigger level in modes 10 and 11.
- R11: The mode, delay word and prescaler selection are captured when a delay launches. Changing them while the delay runs alters neither its length nor its expiry level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; trigger sampled on its falling edge, all else on its rising edge |
| rst | input | 1 | Synchronous abort and reset, active high |
| trig | input | 1 | Trigger level |
| mode | input | 2 | Behaviour select (see R1) |
| delay | input | DELAY_W (8) | Binary-weighted delay word |
| pre_en | input | 1 | Use divided clock as time base |
| pre_alt | input | 1 | Select DIV_B instead of DIV_A |
| dout | output | 1 | Delay output |

## Verification
The hardest case to reach from the ports is a new trigger edge that lands on the exact rising edge where the countdown expires. The edge must win, and the expiry level must never appear. The stimulus reaches this case by timing a low-then-high trigger sequence against a known short delay, so that the second rise is recognised on the expiry cycle. Glitch pulses that lie wholly between a rising and a falling clock edge are also applied, to show that the falling-edge sampler drops them. The prescalers are overridden to small factors so that long words and both dividers run within the cycle budget.

// File: rtl/dly_pkg.sv
package dly_pkg;
  typedef enum logic [1:0] {
    MODE_ONESHOT = 2'b00,
    MODE_OPERATE = 2'b01,
    MODE_RELEASE = 2'b10,
    MODE_DUAL    = 2'b11
  } dly_mode_e;
endpackage

// File: rtl/dly_trig_edge.sv
module dly_trig_edge (
  input  logic clk,
  input  logic trig_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic prev_lvl;

  // trigger is captured on the falling clock edge
  always_ff @(negedge clk) level <= trig_in;

  always_ff @(posedge clk) prev_lvl <= level;

  assign rise = level & ~prev_lvl;
  assign fall = ~level & prev_lvl;
endmodule

// File: rtl/dly_prescaler.sv
module dly_prescaler #(
  parameter int DIV_A = 3000,
  parameter int DIV_B = 3600
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic en,
  input  logic alt,
  output logic tick
);
  localparam int MAXD = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int W    = (MAXD > 1) ? $clog2(MAXD) : 1;
  localparam logic [W-1:0] LIM_A = W'(DIV_A - 1);
  localparam logic [W-1:0] LIM_B = W'(DIV_B - 1);

  logic         en_q, alt_q;
  logic [W-1:0] pcnt;
  logic [W-1:0] lim_m1;

  assign lim_m1 = alt_q ? LIM_B : LIM_A;
  assign tick   = !en_q || (pcnt == lim_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt  <= '0;
      en_q  <= 1'b0;
      alt_q <= 1'b0;
    end else if (restart) begin
      pcnt  <= '0;
      en_q  <= en;
      alt_q <= alt;
    end else if (en_q) begin
      pcnt <= (pcnt == lim_m1) ? '0 : pcnt + 1'b1;
    end
  end

  p_pcnt_range_r8: assert property (@(posedge clk) disable iff (rst)
    en_q |-> (pcnt <= lim_m1));
  p_restart_phase_r8: assert property (@(posedge clk) disable iff (rst)
    restart |=> (pcnt == '0));
endmodule

// File: rtl/dly_counter.sv
module dly_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          cancel,
  input  logic          tick,
  input  logic [CW-1:0] load_val,
  output logic          expire,
  output logic          busy
);
  logic [CW-1:0] cnt;

  assign expire = busy && tick && (cnt == '0) && !load && !cancel;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= load_val;
    end else if (cancel) begin
      busy <= 1'b0;
    end else if (busy && tick) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  p_abort_r10: assert property (@(posedge clk)
    rst |=> !busy);
  p_load_busy_r7: assert property (@(posedge clk) disable iff (rst)
    load |=> (busy && cnt == $past(load_val)));
  p_hold_between_ticks_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick && !load && !cancel) |=> $stable(cnt));
endmodule

// File: rtl/prog_delay_timer.sv
module prog_delay_timer
  import dly_pkg::*;
#(
  parameter int DELAY_W = 8,
  parameter int DIV_A   = 3000,
  parameter int DIV_B   = 3600
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trig,
  input  logic [1:0]         mode,
  input  logic [DELAY_W-1:0] delay,
  input  logic               pre_en,
  input  logic               pre_alt,
  output logic               dout
);
  logic      trig_lvl, rise, fall;
  logic      start, cancel, force_en, force_val;
  logic      tick, expire, busy;
  logic      expire_val, idle_val;
  dly_mode_e live_mode, held_mode;

  assign live_mode = dly_mode_e'(mode);

  dly_trig_edge u_edge (
    .clk     (clk),
    .trig_in (trig),
    .level   (trig_lvl),
    .rise    (rise),
    .fall    (fall)
  );

  dly_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (start),
    .en      (pre_en),
    .alt     (pre_alt),
    .tick    (tick)
  );

  dly_counter #(.CW(DELAY_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (start),
    .cancel   (cancel),
    .tick     (tick),
    .load_val (delay),
    .expire   (expire),
    .busy     (busy)
  );

  // edge decode follows the live mode
  always_comb begin
    start     = 1'b0;
    cancel    = 1'b0;
    force_en  = 1'b0;
    force_val = 1'b0;
    case (live_mode)
      MODE_ONESHOT: begin
        if (rise) begin
          start    = 1'b1;
          force_en = 1'b1;
        end
      end
      MODE_OPERATE: begin
        if (rise) start = 1'b1;
        else if (fall) begin
          cancel    = 1'b1;
          force_en  = 1'b1;
          force_val = 1'b1;
        end
      end
      MODE_RELEASE: begin
        if (fall) start = 1'b1;
        else if (rise) begin
          cancel   = 1'b1;
          force_en = 1'b1;
        end
      end
      default: begin
        if (rise || fall) start = 1'b1;
      end
    endcase
  end

  // expiry level follows the mode captured at launch
  always_comb begin
    case (held_mode)
      MODE_ONESHOT: expire_val = 1'b1;
      MODE_OPERATE: expire_val = 1'b0;
      MODE_RELEASE: expire_val = 1'b1;
      default:      expire_val = ~trig_lvl;
    endcase
  end

  assign idle_val = live_mode[1] ? ~trig_lvl : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_mode <= MODE_ONESHOT;
      dout      <= idle_val;
    end else begin
      if (start) held_mode <= live_mode;
      if (force_en)    dout <= force_val;
      else if (expire) dout <= expire_val;
    end
  end

  p_os_rise_low_r2: assert property (@(posedge clk) disable iff (rst)
    (live_mode == MODE_ONESHOT && rise) |=> !dout);
  p_op_fall_high_r4: assert property (@(posedge clk) disable iff (rst)
    (live_mode == MODE_OPERATE && fall) |=> (dout && !busy));
  p_rel_rise_low_r5: assert property (@(posedge clk) disable iff (rst)
    (live_mode == MODE_RELEASE && rise) |=> (!dout && !busy));
  p_dual_expire_r6: assert property (@(posedge clk) disable iff (rst)
    (expire && held_mode == MODE_DUAL) |=> (dout == !$past(trig_lvl)));
  p_os_fall_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (live_mode == MODE_ONESHOT && fall && !expire) |=> $stable(dout));
endmodule

// File: tb/tb_prog_delay_timer.sv
module tb_prog_delay_timer;
  localparam int DA = 3;
  localparam int DB = 5;

  logic       clk = 1'b1;
  logic       rst, trig, pre_en, pre_alt;
  logic [1:0] mode;
  logic [7:0] delay;
  logic       dout;

  int    checks = 0, failures = 0, cyc = 0;
  string cur_req = "R10";
  bit    cmp_on = 0, done = 0;

  // behavioural reference state
  logic ts = 1'b0, pv = 1'b0, eo = 1'b1;
  bit   armed = 0;
  int   rem = 0;
  logic [1:0] lm = 2'b00;

  prog_delay_timer #(.DELAY_W(8), .DIV_A(DA), .DIV_B(DB)) dut (
    .clk(clk), .rst(rst), .trig(trig), .mode(mode), .delay(delay),
    .pre_en(pre_en), .pre_alt(pre_alt), .dout(dout)
  );

  always #10 clk = ~clk;

  function automatic int period(input logic en, input logic alt);
    if (!en) return 1;
    return alt ? DB : DA;
  endfunction

  always @(posedge clk) begin
    logic r, f;
    bit st, cn;
    if (rst) begin
      armed = 0; rem = 0; pv = ts;
      eo = mode[1] ? ~ts : 1'b1;
    end else begin
      r = ts & ~pv; f = ~ts & pv; pv = ts;
      st = 0; cn = 0;
      case (mode)
        2'd0: if (r) begin eo = 1'b0; st = 1; end
        2'd1: if (r) st = 1; else if (f) begin eo = 1'b1; cn = 1; end
        2'd2: if (f) st = 1; else if (r) begin eo = 1'b0; cn = 1; end
        default: if (r | f) st = 1;
      endcase
      if (st) begin
        armed = 1; lm = mode;
        rem = (int'(delay) + 1) * period(pre_en, pre_alt);
      end else if (cn) armed = 0;
      else if (armed) begin
        rem--;
        if (rem == 0) begin
          armed = 0;
          case (lm)
            2'd0, 2'd2: eo = 1'b1;
            2'd1:       eo = 1'b0;
            default:    eo = ~ts;
          endcase
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      checks++;
      if (dout !== eo) begin
        failures++;
        $display("FAIL %s cycle=%0d dout=%b expected=%b", cur_req, cyc, dout, eo);
      end
    end
    ts = trig;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog cycle=%0d actual=running expected=finished", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_rst();
    rst = 1'b1; step(3); rst = 1'b0;
  endtask

  task automatic spot(input logic exp, input string req);
    @(negedge clk); #1;
    checks++;
    if (dout !== exp) begin
      failures++;
      $display("FAIL %s spot dout=%b expected=%b", req, dout, exp);
    end
    step(1);
  endtask

  initial begin
    rst = 1'b1; trig = 1'b0; mode = 2'b00; delay = 8'd4;
    pre_en = 1'b0; pre_alt = 1'b0;
    step(4);
    cmp_on = 1;
    spot(1'b1, "R10");                  // R10 idle high in one-shot
    rst = 1'b0;

    // R2 and R3: one-shot, restart, falling edge ignored
    cur_req = "R2";
    trig = 1'b1; step(4);
    cur_req = "R3";
    trig = 1'b0; step(2); trig = 1'b1; step(12);
    trig = 1'b0; step(10);
    // R3: rise detected on the expiry edge must restart
    delay = 8'd2;
    trig = 1'b1; step(1);
    trig = 1'b0; step(2);
    trig = 1'b1; step(10);
    trig = 1'b0; step(3);

    // R4 delayed operate
    cur_req = "R4"; mode = 2'b01; delay = 8'd3;
    trig = 1'b1; step(8); trig = 1'b0; step(3);
    trig = 1'b1; step(2); trig = 1'b0; step(8);

    // R5 delayed release
    cur_req = "R5"; mode = 2'b10;
    trig = 1'b1; step(3); trig = 1'b0; step(8);
    trig = 1'b1; step(2); trig = 1'b0; step(2); trig = 1'b1; step(8);

    // R1 and R6 dual delay
    cur_req = "R6"; mode = 2'b11; delay = 8'd5;
    trig = 1'b0; step(10); trig = 1'b1; step(3); trig = 1'b0; step(10);
    cur_req = "R1";
    trig = 1'b1; step(10);

    // R7 extremes of the delay word
    cur_req = "R7"; mode = 2'b00; trig = 1'b0; step(2);
    delay = 8'd0; trig = 1'b1; step(4); trig = 1'b0; step(2);
    delay = 8'd255; trig = 1'b1; step(262); trig = 1'b0; step(2);

    // R8 both prescaler factors
    cur_req = "R8"; delay = 8'd2; pre_en = 1'b1; pre_alt = 1'b0;
    trig = 1'b1; step(14); trig = 1'b0; step(2);
    mode = 2'b01; pre_alt = 1'b1; delay = 8'd3;
    trig = 1'b1; step(25); trig = 1'b0; step(3);

    // R11 settings captured at launch
    cur_req = "R11"; mode = 2'b00; pre_alt = 1'b0; delay = 8'd6;
    trig = 1'b1; step(3);
    delay = 8'd1; pre_en = 1'b0; mode = 2'b01;
    step(25); mode = 2'b00; trig = 1'b0; step(3);

    // R9 glitch between rising and falling edges
    cur_req = "R9";
    trig = 1'b1; #4; trig = 1'b0; step(6);
    trig = 1'b1; #4; trig = 1'b0; step(6);

    // R10 abort mid-delay with each idle rule
    cur_req = "R10"; delay = 8'd20;
    trig = 1'b1; step(5); pulse_rst(); step(30);
    trig = 1'b0; step(2);
    mode = 2'b10; trig = 1'b1; step(2); trig = 1'b0; step(4);
    pulse_rst(); step(3); spot(1'b1, "R10");
    mode = 2'b11; trig = 1'b1; step(2); pulse_rst(); step(2);
    spot(1'b0, "R10");
    step(5);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule